// File: doc/BRIEF.md
# System Clock Control with Power-Saving Switchback

This block holds the byte-wide control register that governs the system clock and turns its settings into a clock-enable pulse train. Software picks the clock source (high-frequency oscillator or frequency-locked loop), picks a normal divide ratio of 1, 2, 4 or 8, can request stop mode, and can enter a power-management mode that slows the clock to one enable pulse every 256 cycles.

The power-management mode can end on its own. When the switchback feature is armed, any asserted wake event clears the power-management bit. The divide ratio that was programmed before entry then applies again. While power-management mode is on, the divider field is frozen. Software also cannot arm switchback while a wake event is already present.

A read returns the live register image. This includes a read-only flag that reports whether the loop is really driving the clock. That is true when the loop is selected, and also while the oscillator is still warming up.

Top module: `clkctl_top`

## Requirements
- R1: After reset the register reads 8'h60 with `osc_ready` high: the source-select bit (bit 6) is 1, the loop-active flag (bit 5) is 1, and all other bits are 0. `stop_req` is 0.
- R2: Bit 6 selects the source (0 oscillator, 1 loop) and reads back as written. Bit 7 always reads 0.
- R3: Bit 5 is read-only and equals bit 6 OR NOT `osc_ready`. Writes to it have no effect.
- R4: Bit 4 drives `stop_req`. Writing it does not change the divide ratio or restart the pulse train.
- R5: Bits 1:0 (divide select) are writable only while bit 2 (power-management) is 0. Otherwise writes leave them unchanged.
- R6: While bit 2 and bit 3 (switchback enable) are both 1, any asserted bit of `wake_evt` clears bit 2 on the next clock edge.
- R7: A switchback clears only bit 2. Bits 1:0 and bit 3 keep their values.
- R8: While bit 2 is 1 and any wake event is asserted, a write that would set bit 3 from 0 leaves it 0.
- R9: Divide select values 00, 01, 10 and 11 give one-cycle `clk_en` pulses every 1, 2, 4 and 8 cycles.
- R10: With bit 2 set, `clk_en` pulses once every 256 cycles.
- R11: When the effective ratio changes, the first `clk_en` pulse comes one full new period after the clock edge that made the change.
- R12: A wake event has no effect on the register when bit 3 or bit 2 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Live register image |
| wake_evt | input | NUM_WAKE | Wake event requests, one bit per source |
| osc_ready | input | 1 | High-frequency oscillator has finished warming up |
| stop_req | output | 1 | Stop mode request |
| clk_en | output | 1 | Divided clock-enable pulse |

## Verification
The assertions assume that `wake_evt`, `osc_ready`, `wr_en` and `wr_data` are synchronous to `clk` and settle well before each rising edge. They also assume that a write lasts one cycle. The stimulus changes every input only on the falling edge. It uses single-cycle write strobes and holds or pulses wake events there. This means each register transition can be traced to exactly one rising edge. Wake events are pulsed or held only around the points where a switchback or a blocked arming attempt is expected.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   // field positions of the control byte
   localparam int B_SRC  = 6;
   localparam int B_FACT = 5;
   localparam int B_STOP = 4;
   localparam int B_SWB  = 3;
   localparam int B_PMM  = 2;
   localparam int DIVSEL_W = 2;
   localparam int DIV_MAX_LOG2 = (1 << DIVSEL_W) - 1;

   typedef struct packed {
      logic                src_loop;
      logic                stop;
      logic                swb_en;
      logic                pmm_on;
      logic [DIVSEL_W-1:0] div_sel;
   } ctl_t;
endpackage

// File: rtl/clkctl_wake.sv
module clkctl_wake #(
   parameter int NUM_WAKE  = 10,
   parameter bit WAKE_FLOP = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_WAKE-1:0] wake_evt,
   output logic                wake_any
);
   initial begin
      if (NUM_WAKE < 1) $error("NUM_WAKE must be at least 1");
   end

   logic any_c;
   assign any_c = |wake_evt;

   generate
      if (WAKE_FLOP) begin : g_flop
         logic any_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) any_q <= 1'b0;
            else        any_q <= any_c;
         end
         assign wake_any = any_q;
      end else begin : g_comb
         assign wake_any = any_c;
      end
   endgenerate
endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
   import clkctl_pkg::*;
#(
   parameter bit SRC_RST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       wake_any,
   output ctl_t       ctl
);
   ctl_t q;
   logic switchback;
   logic swb_block;

   assign switchback = q.pmm_on && q.swb_en && wake_any;
   assign swb_block  = q.pmm_on && wake_any && wr_data[B_SWB] && !q.swb_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.src_loop <= SRC_RST;
         q.stop     <= 1'b0;
         q.swb_en   <= 1'b0;
         q.pmm_on   <= 1'b0;
         q.div_sel  <= '0;
      end else begin
         if (wr_en) begin
            q.src_loop <= wr_data[B_SRC];
            q.stop     <= wr_data[B_STOP];
            if (!swb_block) q.swb_en <= wr_data[B_SWB];
            if (!q.pmm_on)  q.div_sel <= wr_data[DIVSEL_W-1:0];
         end
         if (switchback)  q.pmm_on <= 1'b0;
         else if (wr_en)  q.pmm_on <= wr_data[B_PMM];
      end
   end

   assign ctl = q;

   // R5: divider select frozen while power-management is on
   a_r5_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (q.pmm_on && wr_en) |=> $stable(q.div_sel));
   // R6: switchback clears power-management
   a_r6_switchback: assert property (@(posedge clk) disable iff (!rst_n)
      (q.pmm_on && q.swb_en && wake_any) |=> !q.pmm_on);
   // R7: switchback keeps divider select and enable
   a_r7_keep_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (q.pmm_on && q.swb_en && wake_any) |=> ($stable(q.div_sel) && q.swb_en));
   // R8: arming refused while a wake event is pending
   a_r8_arm_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (q.pmm_on && wake_any && wr_en && !q.swb_en) |=> !q.swb_en);
   // R12: no wake effect without switchback armed
   a_r12_wake_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (q.pmm_on && !q.swb_en && !wr_en) |=> q.pmm_on);
endmodule

// File: rtl/clkctl_div.sv
module clkctl_div #(
   parameter int CNT_W  = 8,
   parameter int LOG2_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LOG2_W-1:0] log2_in,
   output logic              pulse
);
   initial begin
      if (CNT_W < 1)  $error("CNT_W must be at least 1");
      if ((1 << LOG2_W) <= CNT_W) $error("LOG2_W too narrow for CNT_W");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [LOG2_W-1:0] log2_q;
   logic [CNT_W-1:0]  term;
   logic              changed;
   logic              at_term;

   assign term    = {CNT_W{1'b1}} >> (CNT_W - int'(log2_in));
   assign changed = (log2_in != log2_q);
   assign at_term = (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         log2_q <= '0;
      end else begin
         log2_q <= log2_in;
         if (changed || at_term) cnt_q <= '0;
         else                    cnt_q <= cnt_q + 1'b1;
      end
   end

   assign pulse = at_term && !changed;

   // R9: pulses are single cycle for any ratio above one
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && log2_in != '0 && $stable(log2_in)) |=> !pulse);
   // R11: count restarts when the ratio moves
   a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (log2_in != log2_q) |=> (cnt_q == '0));
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
   import clkctl_pkg::*;
#(
   parameter int NUM_WAKE  = 10,
   parameter int PMM_LOG2  = 8,
   parameter bit WAKE_FLOP = 1'b0,
   parameter bit SRC_RST   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [7:0]          wr_data,
   output logic [7:0]          rd_data,
   input  logic [NUM_WAKE-1:0] wake_evt,
   input  logic                osc_ready,
   output logic                stop_req,
   output logic                clk_en
);
   localparam int LOG2_W = $clog2(PMM_LOG2 + 1);

   initial begin
      if (PMM_LOG2 <= DIV_MAX_LOG2) $error("PMM_LOG2 must exceed the normal ratios");
      if (PMM_LOG2 > 16)            $error("PMM_LOG2 limited to 16");
   end

   logic              wake_any;
   ctl_t              ctl;
   logic [LOG2_W-1:0] eff_log2;
   logic              loop_active;
   logic              unused_bits;

   assign unused_bits = ^{wr_data[7], wr_data[B_FACT]};

   clkctl_wake #(.NUM_WAKE(NUM_WAKE), .WAKE_FLOP(WAKE_FLOP)) u_wake (
      .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .wake_any(wake_any));

   clkctl_reg #(.SRC_RST(SRC_RST)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wake_any(wake_any), .ctl(ctl));

   assign eff_log2 = ctl.pmm_on ? LOG2_W'(PMM_LOG2) : LOG2_W'(ctl.div_sel);

   clkctl_div #(.CNT_W(PMM_LOG2), .LOG2_W(LOG2_W)) u_div (
      .clk(clk), .rst_n(rst_n), .log2_in(eff_log2), .pulse(clk_en));

   assign loop_active = ctl.src_loop || !osc_ready;
   assign stop_req    = ctl.stop;
   assign rd_data     = {1'b0, ctl.src_loop, loop_active, ctl.stop,
                         ctl.swb_en, ctl.pmm_on, ctl.div_sel};

   // R3: loop flag tracks an unready oscillator
   a_r3_loop_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_ready |-> rd_data[B_FACT]);
   // R2: reserved bit never set
   a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[7]);
endmodule

// File: tb/sim_clkctl_top.sv
`timescale 1ns/1ps
module sim_clkctl_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [9:0] wake_evt = '0;
   logic       osc_ready = 1'b1;
   logic       stop_req;
   logic       clk_en;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   clkctl_top u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .wake_evt(wake_evt), .osc_ready(osc_ready),
      .stop_req(stop_req), .clk_en(clk_en));

   // {write data, expected read, expected period}
   localparam logic [24:0] VEC [0:4] = '{
      {8'h02, 8'h02, 9'd4},    // R9 divide 4
      {8'h41, 8'h61, 9'd2},    // R2 R9 divide 2, loop selected
      {8'h03, 8'h03, 9'd8},    // R9 divide 8
      {8'h40, 8'h60, 9'd1},    // R9 divide 1
      {8'h06, 8'h06, 9'd256}   // R10 power-management
   };

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic to_pulse(output int n);
      n = 0;
      do begin
         @(negedge clk); n++;
      end while (!clk_en && n < 600);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset image", rd_data, 8'h60);
      check("R1 stop_req", stop_req, 0);

      foreach (VEC[i]) begin
         wr(VEC[i][24:17]);
         check("R9 readback", rd_data, VEC[i][16:9]);
         to_pulse(n);
         check("R11 first pulse", n, VEC[i][8:0]);
         to_pulse(n);
         check("R9 R10 period", n, VEC[i][8:0]);
      end

      wr(8'h05);
      check("R5 divider locked", rd_data, 8'h06);
      @(negedge clk); wake_evt = 10'h200;
      @(negedge clk); wake_evt = '0;
      check("R12 wake without arm", rd_data, 8'h06);
      @(negedge clk); wake_evt = 10'h001;
      wr(8'h0E);
      wake_evt = '0;
      check("R8 arm refused", rd_data, 8'h06);
      wr(8'h0E);
      check("R8 arm accepted", rd_data, 8'h0E);
      @(negedge clk); wake_evt = 10'h008;
      @(negedge clk); wake_evt = '0;
      check("R6 R7 switchback", rd_data, 8'h0A);
      to_pulse(n);
      check("R11 restart after switchback", n, 4);

      wr(8'h1A);
      check("R4 stop_req", stop_req, 1);
      to_pulse(n);
      to_pulse(n);
      check("R4 ratio kept", n, 4);
      @(negedge clk); wake_evt = 10'h3FF;
      @(negedge clk); wake_evt = '0;
      check("R12 wake with pmm off", rd_data, 8'h1A);

      wr(8'h20);
      check("R3 flag not writable", rd_data, 8'h00);
      osc_ready = 1'b0;
      @(negedge clk);
      check("R3 flag while warming", rd_data, 8'h20);
      osc_ready = 1'b1;
      wr(8'hC0);
      check("R2 reserved reads zero", rd_data, 8'h60);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule